// File: doc/BRIEF.md
# Pixel Clock Synthesiser Parameter Solver

This block converts a requested pixel period, given in picoseconds, into the three settings of a frequency synthesiser: a multiplier `k` (5 bits), a divider `n` (7 bits) and a post-shift `p` (2 bits). It works through every multiplier from 1 to 31 in turn. For each one it divides the multiplier times a fixed base constant by a scaled target period. It keeps the multiplier that leaves the smallest remainder while keeping the quotient within the range the divider field can hold.

A client waits for `ready`, then pulses `start` with the period on `period`. While the search runs, one shared restoring divider serves all 31 trials and `ready` stays low. When `ready` returns high, the three parameter outputs and the `err` flag hold the result until the next request finishes.

Top module: `pclk_param_solver`

## Requirements
- R1: After reset, `ready` is 1 and `k_out`, `n_out`, `p_out` and `err` are all 0.
- R2: A `start` pulse is taken only while `ready` is 1. `ready` is 0 from the next clock edge until the result is presented. A `start` pulse while `ready` is 0 has no effect on the result.
- R3: A requested period below 5000 is replaced by 5000 before any other step.
- R4: If the clamped period exceeds 2048128 (the base constant 256016 times 8), the request fails. The result shows `err`=1 with all parameters 0, and `ready` returns to 1 on the second clock edge after `start`.
- R5: The post-shift `p_out` is 3 (binary 11) when 16 times the clamped period is below 256016, that is for periods up to 16000. Otherwise it is 2 (binary 10). The scaled target is the clamped period shifted left by that amount.
- R6: For each multiplier k the trial divider is n = (256016·k) / target, with remainder (256016·k) mod target. A trial qualifies only when 1 ≤ n ≤ 127.
- R7: Among the qualifying trials, the result is the one with the smallest remainder. On equal remainders the smaller k wins, so the first qualifying k always displaces the initial bound, which equals the target.
- R8: If no multiplier qualifies, the result shows `err`=1 with all parameters 0.
- R9: The outputs keep the previous result unchanged while a new search is running.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; taken only while ready is 1 |
| period | input | 32 | Requested pixel period in picoseconds |
| ready | output | 1 | High when idle and the outputs hold a valid result |
| k_out | output | 5 | Selected multiplier |
| n_out | output | 7 | Selected divider |
| p_out | output | 2 | Selected post-shift (2 or 3) |
| err | output | 1 | The last request found no usable parameters |

## Verification
The hardest situation to reach is the failure where the period is legal but no multiplier qualifies. It occurs only in the narrow band of periods just below the range limit, where every quotient rounds down to zero. The stimulus places periods on both edges of that band (1984124 and 1984125) and at the limit itself. The stimulus also places a period whose target divides the base exactly (16001), so several multipliers tie at a zero remainder. A second `start` pulse is also injected in the middle of a running search, to show that it leaves the result unchanged.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int K_W = 5;
    localparam int N_W = 7;
    localparam int P_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } srch_state_e;
endpackage

// File: rtl/pclk_prep.sv
// Clamps the requested period, checks the range and picks the post-shift.
module pclk_prep #(
    parameter int PER_W   = 32,
    parameter int BASE    = 256016,
    parameter int MIN_PER = 5000,
    parameter int DW      = 23
) (
    input  logic [PER_W-1:0] period,
    output logic             range_err,
    output logic             shift3,
    output logic [DW-1:0]    target
);
    localparam logic [PER_W-1:0] MIN_V   = PER_W'(MIN_PER);
    localparam logic [PER_W-1:0] LIMIT_V = PER_W'(BASE) << 3;
    localparam logic [PER_W-1:0] THR_V   = PER_W'((BASE + 15) / 16);

    logic [PER_W-1:0] per_c;
    logic [DW-1:0]    per_n;

    always_comb begin
        per_c     = (period < MIN_V) ? MIN_V : period;
        range_err = per_c > LIMIT_V;
        shift3    = per_c < THR_V;
        per_n     = per_c[DW-1:0];
        target    = shift3 ? (per_n << 3) : (per_n << 2);
    end
endmodule

// File: rtl/pclk_rdiv.sv
// Restoring divider, one quotient bit per clock.
module pclk_rdiv #(
    parameter int DW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          fin,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] acc;
        logic [DW-1:0] qsh;
        logic          busy;
        logic          fin;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DW:0] shifted;
    logic [DW:0] diff;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        shifted  = {st_q.acc, st_q.qsh[DW-1]};
        diff     = shifted - {1'b0, divisor};
        if (go) begin
            st_d.acc  = '0;
            st_d.qsh  = dividend;
            st_d.cnt  = CW'(DW);
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (shifted >= {1'b0, divisor}) begin
                st_d.acc = diff[DW-1:0];
                st_d.qsh = {st_q.qsh[DW-2:0], 1'b1};
            end else begin
                st_d.acc = shifted[DW-1:0];
                st_d.qsh = {st_q.qsh[DW-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fin = st_q.fin;
    assign quo = st_q.qsh;
    assign rem = st_q.acc;
endmodule

// File: rtl/pclk_param_solver.sv
// Exhaustive minimum-remainder search over the multiplier range.
module pclk_param_solver
    import pclk_pkg::*;
#(
    parameter int PER_W   = 32,
    parameter int BASE    = 256016,
    parameter int MIN_PER = 5000,
    parameter int K_LAST  = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] period,
    output logic             ready,
    output logic [K_W-1:0]   k_out,
    output logic [N_W-1:0]   n_out,
    output logic [P_W-1:0]   p_out,
    output logic             err
);
    localparam int DW    = $clog2(BASE * 32 + 1);
    localparam int N_LIM = 1 << N_W;

    typedef struct packed {
        srch_state_e    st;
        logic [K_W-1:0] k;
        logic [DW-1:0]  prod;
        logic [DW-1:0]  tgt;
        logic           shift3;
        logic [K_W-1:0] best_k;
        logic [N_W-1:0] best_n;
        logic [DW-1:0]  best_rem;
        logic           found;
        logic [K_W-1:0] k_o;
        logic [N_W-1:0] n_o;
        logic [P_W-1:0] p_o;
        logic           err_o;
    } srch_t;

    srch_t s_d, s_q;

    logic          pre_rerr;
    logic          pre_sh3;
    logic [DW-1:0] pre_tgt;
    logic          div_fin;
    logic [DW-1:0] div_quo;
    logic [DW-1:0] div_rem;
    logic          div_go;
    logic          qualifies;

    pclk_prep #(
        .PER_W(PER_W), .BASE(BASE), .MIN_PER(MIN_PER), .DW(DW)
    ) u_prep (
        .period   (period),
        .range_err(pre_rerr),
        .shift3   (pre_sh3),
        .target   (pre_tgt)
    );

    assign div_go = (s_q.st == ST_LAUNCH);

    pclk_rdiv #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .dividend(s_q.prod),
        .divisor (s_q.tgt),
        .fin     (div_fin),
        .quo     (div_quo),
        .rem     (div_rem)
    );

    always_comb begin
        s_d = s_q;
        qualifies = (div_quo != '0) && (div_quo < DW'(N_LIM))
                    && (div_rem < s_q.best_rem);
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.k        = K_W'(1);
                    s_d.prod     = DW'(BASE);
                    s_d.tgt      = pre_tgt;
                    s_d.shift3   = pre_sh3;
                    s_d.best_k   = '0;
                    s_d.best_n   = '0;
                    s_d.best_rem = pre_tgt;
                    s_d.found    = 1'b0;
                    s_d.st       = pre_rerr ? ST_FINISH : ST_LAUNCH;
                end
            end
            ST_LAUNCH: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (div_fin) begin
                    if (qualifies) begin
                        s_d.best_k   = s_q.k;
                        s_d.best_n   = div_quo[N_W-1:0];
                        s_d.best_rem = div_rem;
                        s_d.found    = 1'b1;
                    end
                    if (s_q.k == K_W'(K_LAST)) begin
                        s_d.st = ST_FINISH;
                    end else begin
                        s_d.k    = s_q.k + 1'b1;
                        s_d.prod = s_q.prod + DW'(BASE);
                        s_d.st   = ST_LAUNCH;
                    end
                end
            end
            ST_FINISH: begin
                s_d.k_o   = s_q.found ? s_q.best_k : '0;
                s_d.n_o   = s_q.found ? s_q.best_n : '0;
                s_d.p_o   = s_q.found ? (s_q.shift3 ? P_W'(3) : P_W'(2)) : '0;
                s_d.err_o = !s_q.found;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = (s_q.st == ST_IDLE);
    assign k_out = s_q.k_o;
    assign n_out = s_q.n_o;
    assign p_out = s_q.p_o;
    assign err   = s_q.err_o;
endmodule

// File: rtl/pclk_param_solver_chk.sv
module pclk_param_solver_chk #(
    parameter int PER_W = 32,
    parameter int BASE  = 256016
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [PER_W-1:0] period,
    input logic             ready,
    input logic [4:0]       k_out,
    input logic [6:0]       n_out,
    input logic [1:0]       p_out,
    input logic             err
);
    localparam logic [PER_W-1:0] LIM = PER_W'(BASE) << 3;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready); // R2

    AST_RANGE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && period > LIM) |=> ##1 (ready && err)); // R4

    AST_GOOD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && !err) |-> (k_out != 0 && n_out != 0 && p_out[1])); // R5

    AST_ERR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && err) |-> (k_out == 0 && n_out == 0 && p_out == 0)); // R8

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready || $stable({k_out, n_out, p_out, err}))); // R9
endmodule

bind pclk_param_solver pclk_param_solver_chk #(.PER_W(PER_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .period(period), .ready(ready),
    .k_out(k_out), .n_out(n_out), .p_out(p_out), .err(err)
);

// File: tb/sim_pclk_param_solver.sv
module sim_pclk_param_solver;
    localparam longint BASE = 256016;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] period = '0;
    logic        ready;
    logic [4:0]  k_out;
    logic [6:0]  n_out;
    logic [1:0]  p_out;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done_all = 1'b0;

    typedef struct {
        logic [31:0] per;
        logic [4:0]  k;
        logic [6:0]  n;
        logic [1:0]  p;
        logic        e;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last_res;

    always #2.5 clk = ~clk;

    pclk_param_solver u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .period(period),
        .ready(ready), .k_out(k_out), .n_out(n_out), .p_out(p_out), .err(err)
    );

    function automatic exp_t model(input logic [31:0] per, input string tag);
        exp_t r;
        longint c, l, best, m;
        int p;
        r.per = per; r.tag = tag; r.k = 0; r.n = 0; r.p = 0; r.e = 1;
        c = (per < 5000) ? 5000 : longint'(per);           // R3
        if (c > BASE * 8) return r;                          // R4
        p = (c * 16 < BASE) ? 3 : 2;                         // R5
        l = c << p;
        best = l;
        for (int kk = 1; kk <= 31; kk++) begin               // R6, R7
            m = BASE * kk;
            if ((m / l) != 0 && (m / l) < 128 && (m % l) < best) begin
                best = m % l;
                r.k = 5'(kk);
                r.n = 7'(m / l);
                r.p = 2'(p);
                r.e = 0;
            end
        end
        if (r.e) r.p = 0;                                    // R8
        return r;
    endfunction

    task automatic check1(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    task automatic apply(input logic [31:0] per, input string tag, input bit poke_busy);
        exp_t e;
        e = model(per, tag);
        while (!ready) @(negedge clk);
        q.push_back(e);
        start  = 1'b1;
        period = per;
        @(negedge clk);
        start = 1'b0;
        check1(!ready, "R2", $sformatf("ready=%0b", ready), "ready=0");
        check1({k_out, n_out, p_out, err} == {last_res.k, last_res.n, last_res.p, last_res.e},
               "R9", $sformatf("k=%0d n=%0d p=%0d e=%0b", k_out, n_out, p_out, err),
               $sformatf("k=%0d n=%0d p=%0d e=%0b", last_res.k, last_res.n, last_res.p, last_res.e));
        if (poke_busy) begin
            repeat (40) @(negedge clk);
            start  = 1'b1;                                   // R2: ignored while busy
            period = 32'd100000;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // monitor: pops expected results when ready rises
    initial begin
        bit rdy_prev = 1'b1;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && ready && !rdy_prev) begin
                if (q.size() == 0) begin
                    check1(1'b0, "R2", "unexpected result", "none");
                end else begin
                    e = q.pop_front();
                    check1({k_out, n_out, p_out, err} == {e.k, e.n, e.p, e.e}, e.tag,
                           $sformatf("k=%0d n=%0d p=%0d e=%0b", k_out, n_out, p_out, err),
                           $sformatf("k=%0d n=%0d p=%0d e=%0b (period %0d)", e.k, e.n, e.p, e.e, e.per));
                    last_res = e;
                end
            end
            rdy_prev = ready;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        last_res = '{per: 0, k: 0, n: 0, p: 0, e: 0, tag: "R1"};
        repeat (3) @(negedge clk);
        check1(ready && k_out == 0 && n_out == 0 && p_out == 0 && !err, "R1",
               $sformatf("rdy=%0b k=%0d n=%0d p=%0d e=%0b", ready, k_out, n_out, p_out, err),
               "rdy=1 all zero");
        rst_n = 1'b1;
        @(negedge clk);
        check1(ready && !err, "R1", $sformatf("rdy=%0b e=%0b", ready, err), "rdy=1 e=0");

        apply(32'd39721,      "R6 typical",             1'b0);
        apply(32'd0,          "R3 clamp zero",          1'b0);
        apply(32'd4999,       "R3 clamp 4999",          1'b0);
        apply(32'd5000,       "R6 n limit at 5000",     1'b0);
        apply(32'd16000,      "R5 shift3 edge",         1'b0);
        apply(32'd16001,      "R7 tie smallest k",      1'b0);
        apply(32'd100000,     "R2 busy start ignored",  1'b1);
        apply(32'd1984124,    "R6 last good band",      1'b0);
        apply(32'd1984125,    "R8 no candidate",        1'b0);
        apply(32'd2048128,    "R8 at limit",            1'b0);
        apply(32'd25000,      "R7 after error",         1'b0);
        apply(32'd2048129,    "R4 range",               1'b0);
        apply(32'hFFFF_FFFF,  "R4 range max",           1'b0);
        apply(32'd65536,      "R6 mid",                 1'b0);

        while (q.size() != 0 || !ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check1(ready && k_out == last_res.k && err == last_res.e, "R9",
               $sformatf("k=%0d e=%0b", k_out, err),
               $sformatf("k=%0d e=%0b", last_res.k, last_res.e));
        done_all = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule